// File: doc/BRIEF.md
# Serial I/Q Frame Capture Controller

This block sits behind a digital down-converter that emits a synchronous serial stream: one bit clock (which also clocks this block), a one-cycle frame strobe and a single data line. Each frame carries 96 bits made of four 24-bit fields. The block shifts in every frame and keeps only the field named by a channel-select and a phase-select input. It left-justifies that field when the converter's output is narrower than 24 bits, and commits the word to an on-block memory through a slow multi-phase write sequencer.

A capture starts with a one-cycle arm pulse. The pulse rewinds the write address, clears the status and enables storage. The block stores one word per accepted frame until every memory entry is full, then raises done. A strobe that comes too soon after the previous accepted strobe is rejected and latches a sticky overrun flag, so the word being written is never disturbed. The block also drives a reference clock derived from the bit clock for phase-locking an external source. A synchronous read port returns stored words for later readout.

Top module: `iq_frame_capture`

## Requirements
- R1: A frame starts on a bit-clock rising edge where `frm_strobe` is high; that edge samples the frame's first bit and the next 95 edges sample the rest. Data arrives MSB first. Received bit order is field 0 (channel A in-phase), field 1 (channel A quadrature), field 2 (channel B in-phase), field 3 (channel B quadrature), 24 bits each.
- R2: The stored field index is {`ch_sel`,`ph_sel`}. `ch_sel` 0 is channel A and 1 is channel B. `ph_sel` 0 is in-phase and 1 is quadrature. The selects are sampled one cycle after the frame's last bit, and the other three fields are dropped.
- R3: With parameter `FIELD_W` below 24, the block keeps the top `FIELD_W` bits of the chosen field and stores the low 24-`FIELD_W` bits as zero.
- R4: An `arm` pulse sets `capturing`, clears `done` and `overrun`, and restarts storage at address 0. Accepted frames are then stored at consecutive addresses. Frames completed while `capturing` is low are not stored.
- R5: Each memory write runs through three phases (address setup, write strobe, release) of `PHASE_CYC` cycles each, 6 cycles by default. The address and data stay stable throughout.
- R6: After the write to the last address (2^`ADDR_W`-1), `done` rises and `capturing` falls.
- R7: A strobe fewer than `MIN_GAP` (192) bit clocks after the previous accepted strobe is ignored: no word is stored from it. It also sets `overrun`, which stays set until the next `arm` or reset. A strobe exactly `MIN_GAP` clocks later is accepted.
- R8: `ref_clk` toggles every max(`rate`,2) bit clocks, so its period is 2·max(`rate`,2) bit clocks. A rate of 0 or 1 behaves as 2.
- R9: `rd_data` shows the memory word at `rd_addr` one clock after `rd_addr` is presented.
- R10: After reset, `capturing`, `done`, `overrun` and `ref_clk` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, also the block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_strobe | input | 1 | Frame start marker, high with the first bit |
| sdata | input | 1 | Serial data line |
| ch_sel | input | 1 | Channel select: 0 = A, 1 = B |
| ph_sel | input | 1 | Phase select: 0 = in-phase, 1 = quadrature |
| rate | input | RATE_W | Reference clock divide setting |
| arm | input | 1 | One-cycle pulse that starts a capture |
| capturing | output | 1 | Capture in progress |
| done | output | 1 | Memory filled |
| overrun | output | 1 | Sticky early-strobe flag |
| ref_clk | output | 1 | Divided reference clock |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 24 | Word read from memory |

## Verification
The assertions take for granted that `arm` is a single-cycle pulse and that `frm_strobe` is a single-cycle marker. Frame spacing is never assumed: the block enforces it, so it may check that no completed word meets a busy write sequencer. The stimulus drives every input on the falling clock edge. It keeps `ch_sel`/`ph_sel` steady from strobe until the next frame, and it spaces frames at exactly `MIN_GAP`, with one deliberate `MIN_GAP`-1 frame to provoke an overrun.

// File: rtl/iq_cap_pkg.sv
package iq_cap_pkg;
    localparam int FIELD_BITS = 24;
    localparam int NUM_FIELDS = 4;
    localparam int FRAME_BITS = FIELD_BITS * NUM_FIELDS;

    typedef logic [FIELD_BITS-1:0] word_t;
    typedef logic [FRAME_BITS-1:0] frame_t;

    typedef enum logic [1:0] {
        WR_IDLE    = 2'd0,
        WR_SETUP   = 2'd1,
        WR_STROBE  = 2'd2,
        WR_RELEASE = 2'd3
    } wr_state_e;
endpackage

// File: rtl/iq_deser.sv
module iq_deser
    import iq_cap_pkg::*;
#(
    parameter int MIN_GAP = 192
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   arm,
    input  logic   frm_strobe,
    input  logic   sdata,
    output logic   frame_vld,
    output frame_t frame_data,
    output logic   overrun
);
    localparam int GAP_W = $clog2(MIN_GAP + 1);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        frame_t             shreg;
        logic [CNT_W-1:0]   bit_cnt;
        logic               busy;
        logic [GAP_W-1:0]   gap;
        logic               ovr;
        logic               vld;
    } deser_t;

    deser_t d_d, d_q;
    logic   accept;

    always_comb begin
        d_d     = d_q;
        d_d.vld = 1'b0;
        accept  = frm_strobe && (d_q.gap >= GAP_W'(MIN_GAP));

        if (d_q.gap < GAP_W'(MIN_GAP)) begin
            d_d.gap = d_q.gap + 1'b1;
        end

        if (frm_strobe && !accept) begin
            d_d.ovr = 1'b1;
        end

        if (accept) begin
            d_d.busy    = 1'b1;
            d_d.shreg   = {d_q.shreg[FRAME_BITS-2:0], sdata};
            d_d.bit_cnt = CNT_W'(1);
            d_d.gap     = GAP_W'(1);
        end else if (d_q.busy) begin
            d_d.shreg = {d_q.shreg[FRAME_BITS-2:0], sdata};
            if (d_q.bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
                d_d.busy    = 1'b0;
                d_d.vld     = 1'b1;
                d_d.bit_cnt = '0;
            end else begin
                d_d.bit_cnt = d_q.bit_cnt + 1'b1;
            end
        end

        if (arm) begin
            d_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q       <= '0;
            d_q.gap   <= GAP_W'(MIN_GAP);
        end else begin
            d_q <= d_d;
        end
    end

    assign frame_vld  = d_q.vld;
    assign frame_data = d_q.shreg;
    assign overrun    = d_q.ovr;

    // R7: overrun holds until arm
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.ovr && !arm) |=> d_q.ovr);

    // R1: a frame that stops shifting always yields a complete frame
    p_frame_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(d_q.busy) |-> d_q.vld);

    // R7: a rejected strobe leaves the shift state untouched
    p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_strobe && d_q.gap < GAP_W'(MIN_GAP) && !d_q.busy) |=> !d_q.busy);
endmodule

// File: rtl/iq_field_sel.sv
module iq_field_sel
    import iq_cap_pkg::*;
#(
    parameter int FIELD_W = 24
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_vld,
    input  frame_t frame_data,
    input  logic   ch_sel,
    input  logic   ph_sel,
    output logic   word_vld,
    output word_t  word
);
    localparam int    PAD_W = FIELD_BITS - FIELD_W;
    localparam word_t KEEP  = ~((word_t'(1) << PAD_W) - word_t'(1));

    typedef struct packed {
        logic  vld;
        word_t data;
    } sel_t;

    sel_t   s_d, s_q;
    word_t  fields [NUM_FIELDS];
    logic [1:0] idx;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign fields[f] = frame_data[FRAME_BITS-1-FIELD_BITS*f -: FIELD_BITS];
    end

    always_comb begin
        idx      = {ch_sel, ph_sel};
        s_d      = s_q;
        s_d.vld  = frame_vld;
        if (frame_vld) begin
            s_d.data = fields[idx] & KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_vld = s_q.vld;
    assign word     = s_q.data;

    if (PAD_W > 0) begin : g_pad_chk
        // R3: low bits of a narrow field are zero
        p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.vld |-> (s_q.data[PAD_W-1:0] == '0));
    end
endmodule

// File: rtl/iq_wr_seq.sv
module iq_wr_seq
    import iq_cap_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PHASE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              word_vld,
    input  word_t             word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              capturing,
    output logic              done,
    output word_t             rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PH_W  = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

    typedef struct packed {
        wr_state_e         st;
        logic [PH_W-1:0]   ph_cnt;
        logic [ADDR_W-1:0] addr;
        word_t             wdata;
        logic              active;
        logic              done;
    } seq_t;

    seq_t  w_d, w_q;
    logic  ph_last;
    logic  mem_we;
    word_t mem_q [DEPTH];
    word_t rd_q;

    always_comb begin
        w_d     = w_q;
        ph_last = (w_q.ph_cnt == PH_W'(PHASE_CYC - 1));
        unique case (w_q.st)
            WR_IDLE: begin
                if (word_vld && w_q.active) begin
                    w_d.st     = WR_SETUP;
                    w_d.wdata  = word;
                    w_d.ph_cnt = '0;
                end
            end
            WR_SETUP, WR_STROBE: begin
                if (ph_last) begin
                    w_d.ph_cnt = '0;
                    w_d.st     = (w_q.st == WR_SETUP) ? WR_STROBE : WR_RELEASE;
                end else begin
                    w_d.ph_cnt = w_q.ph_cnt + 1'b1;
                end
            end
            WR_RELEASE: begin
                if (ph_last) begin
                    w_d.ph_cnt = '0;
                    w_d.st     = WR_IDLE;
                    if (&w_q.addr) begin
                        w_d.active = 1'b0;
                        w_d.done   = 1'b1;
                    end else begin
                        w_d.addr = w_q.addr + 1'b1;
                    end
                end else begin
                    w_d.ph_cnt = w_q.ph_cnt + 1'b1;
                end
            end
            default: w_d.st = WR_IDLE;
        endcase

        if (arm) begin
            w_d.st     = WR_IDLE;
            w_d.ph_cnt = '0;
            w_d.addr   = '0;
            w_d.active = 1'b1;
            w_d.done   = 1'b0;
        end
    end

    assign mem_we = (w_q.st == WR_STROBE) && (w_q.ph_cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem_q[w_q.addr] <= w_q.wdata;
        end
        rd_q <= mem_q[rd_addr];
    end

    assign capturing = w_q.active;
    assign done      = w_q.done;
    assign rd_data   = rd_q;

    // R5: address and data frozen while the write is in flight
    p_hold_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((w_q.st == WR_SETUP || w_q.st == WR_STROBE) && !arm)
        |=> ($stable(w_q.addr) && $stable(w_q.wdata)));

    // R5: enforced spacing means no word meets a busy sequencer
    p_word_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && w_q.active) |-> (w_q.st == WR_IDLE));

    // R6: done and capturing are exclusive
    p_done_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.done |-> !w_q.active);

    // R4: arm rewinds the address
    p_arm_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (w_q.addr == '0 && w_q.active && !w_q.done));
endmodule

// File: rtl/iq_ref_div.sv
module iq_ref_div #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              ref_clk
);
    typedef struct packed {
        logic [RATE_W-1:0] cnt;
        logic              ref_o;
    } div_t;

    div_t r_d, r_q;
    logic [RATE_W-1:0] rate_eff;

    always_comb begin
        rate_eff = (rate < RATE_W'(2)) ? RATE_W'(2) : rate;
        r_d      = r_q;
        if (r_q.cnt >= rate_eff - 1'b1) begin
            r_d.cnt   = '0;
            r_d.ref_o = ~r_q.ref_o;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ref_clk = r_q.ref_o;

    // R8: each level lasts at least two bit clocks
    p_ref_min_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ref_o != $past(r_q.ref_o)) |=> $stable(r_q.ref_o));
endmodule

// File: rtl/iq_frame_capture.sv
module iq_frame_capture
    import iq_cap_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int FIELD_W   = 24,
    parameter int RATE_W    = 8,
    parameter int MIN_GAP   = 192,
    parameter int PHASE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_strobe,
    input  logic              sdata,
    input  logic              ch_sel,
    input  logic              ph_sel,
    input  logic [RATE_W-1:0] rate,
    input  logic              arm,
    output logic              capturing,
    output logic              done,
    output logic              overrun,
    output logic              ref_clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [23:0]       rd_data
);
    logic   frame_vld;
    frame_t frame_data;
    logic   word_vld;
    word_t  word;

    iq_deser #(.MIN_GAP(MIN_GAP)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .frm_strobe (frm_strobe),
        .sdata      (sdata),
        .frame_vld  (frame_vld),
        .frame_data (frame_data),
        .overrun    (overrun)
    );

    iq_field_sel #(.FIELD_W(FIELD_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .frame_data (frame_data),
        .ch_sel     (ch_sel),
        .ph_sel     (ph_sel),
        .word_vld   (word_vld),
        .word       (word)
    );

    iq_wr_seq #(.ADDR_W(ADDR_W), .PHASE_CYC(PHASE_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .word_vld   (word_vld),
        .word       (word),
        .rd_addr    (rd_addr),
        .capturing  (capturing),
        .done       (done),
        .rd_data    (rd_data)
    );

    iq_ref_div #(.RATE_W(RATE_W)) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate       (rate),
        .ref_clk    (ref_clk)
    );

    // R10: quiet outputs right after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!capturing && !done && !overrun && !ref_clk));
endmodule

// File: tb/iq_frame_capture_tb_top.sv
module iq_frame_capture_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int FIELD_W    = 20;
    localparam int MIN_GAP    = 192;
    localparam logic [23:0] KEEP = 24'hFFFFF0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frm_strobe = 1'b0;
    logic              sdata = 1'b0;
    logic              ch_sel = 1'b0;
    logic              ph_sel = 1'b0;
    logic [7:0]        rate = 8'd0;
    logic              arm = 1'b0;
    logic              capturing, done, overrun, ref_clk;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [23:0]       rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    bit mon_go   = 1'b0;
    bit mon_done = 1'b0;
    logic [23:0] exp_q [$];
    logic [23:0] first_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_frame_capture #(
        .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .RATE_W(8),
        .MIN_GAP(MIN_GAP), .PHASE_CYC(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .frm_strobe(frm_strobe), .sdata(sdata),
        .ch_sel(ch_sel), .ph_sel(ph_sel), .rate(rate), .arm(arm),
        .capturing(capturing), .done(done), .overrun(overrun),
        .ref_clk(ref_clk), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] fval(input int k, input int f);
        logic [31:0] t;
        t = k * 32'h0001_3579 + f * 32'h0024_681B + 32'h00AB_CDEF;
        return t[23:0];
    endfunction

    // Driver: sends one frame, next strobe comes gap clocks after this one.
    task automatic send_frame(input int k, input int gap, input bit store);
        logic [95:0] fr;
        for (int f = 0; f < 4; f++) fr[95-24*f -: 24] = fval(k, f);
        @(negedge clk);
        ch_sel = k[1];
        ph_sel = k[0];
        for (int b = 95; b >= 0; b--) begin
            frm_strobe = (b == 95);
            sdata      = fr[b];
            if (b != 0) @(negedge clk);
        end
        @(negedge clk);
        frm_strobe = 1'b0;
        sdata      = 1'b0;
        for (int i = 0; i < gap - 97; i++) @(negedge clk);
        if (store) exp_q.push_back(fval(k, k % 4) & KEEP);
    endtask

    task automatic pulse_arm();
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic ref_period(output int per);
        per = 0;
        while (ref_clk !== 1'b0) @(negedge clk);
        while (ref_clk !== 1'b1) @(negedge clk);
        @(negedge clk);
        per = 1;
        while (ref_clk !== 1'b0) begin @(negedge clk); per++; end
        while (ref_clk !== 1'b1) begin @(negedge clk); per++; end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Monitor: reads the memory back and compares with the scoreboard.
    initial begin
        wait (mon_go);
        for (int a = 0; a < DEPTH; a++) begin
            logic [23:0] e;
            @(negedge clk);
            rd_addr = ADDR_W'(a);
            @(negedge clk);
            e = exp_q.pop_front();
            if (a == 0) first_word = e;
            // R1 R2 R9: stored word equals chosen field, read one cycle later
            chk(rd_data === e, "R1/R2/R9 stored word", {8'h0, rd_data}, {8'h0, e});
            // R3: zero fill of the 4 unused low bits
            chk(rd_data[3:0] === 4'h0, "R3 zero fill", {28'h0, rd_data[3:0]}, 32'h0);
        end
        mon_done = 1'b1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        int per;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk({capturing, done, overrun, ref_clk} === 4'b0000, "R10 reset outputs",
            {28'h0, capturing, done, overrun, ref_clk}, 32'h0);

        // R8: clamped and programmed divide
        rate = 8'd0; ref_period(per);
        chk(per == 4, "R8 rate 0 clamps", per, 4);
        rate = 8'd1; ref_period(per); ref_period(per);
        chk(per == 4, "R8 rate 1 clamps", per, 4);
        rate = 8'd5; ref_period(per); ref_period(per);
        chk(per == 10, "R8 rate 5", per, 10);

        // R4: frame before arm is not stored
        send_frame(99, MIN_GAP, 1'b0);
        chk(capturing === 1'b0, "R4 idle before arm", {31'h0, capturing}, 32'h0);
        pulse_arm();
        chk(capturing === 1'b1 && done === 1'b0, "R4 arm starts capture",
            {30'h0, capturing, done}, 32'h2);

        for (int k = 0; k < DEPTH; k++) begin
            if (k == 5) begin
                // R7: next strobe one clock early, then that frame is rejected
                send_frame(k, MIN_GAP - 1, 1'b1);
                send_frame(200, MIN_GAP, 1'b0);
            end else begin
                send_frame(k, MIN_GAP, 1'b1);
            end
        end
        repeat (4) @(negedge clk);
        // R6: completion
        chk(done === 1'b1, "R6 done after last write", {31'h0, done}, 32'h1);
        chk(capturing === 1'b0, "R6 capture stops", {31'h0, capturing}, 32'h0);
        // R7: sticky flag
        chk(overrun === 1'b1, "R7 overrun set", {31'h0, overrun}, 32'h1);

        mon_go = 1'b1;
        wait (mon_done);
        chk(exp_q.size() == 0, "R7 rejected frame not stored", exp_q.size(), 0);

        // R4: frame after done leaves memory untouched
        send_frame(7, MIN_GAP, 1'b0);
        @(negedge clk);
        rd_addr = '0;
        @(negedge clk);
        chk(rd_data === first_word, "R4 no store after done",
            {8'h0, rd_data}, {8'h0, first_word});
        chk(overrun === 1'b1, "R7 overrun still held", {31'h0, overrun}, 32'h1);

        pulse_arm();
        chk(overrun === 1'b0, "R7 arm clears overrun", {31'h0, overrun}, 32'h0);
        chk(done === 1'b0 && capturing === 1'b1, "R4 re-arm",
            {30'h0, capturing, done}, 32'h2);
        finish_run();
    end
endmodule